// File: doc/BRIEF.md
# Tributary Slot Interface for a Byte-Parallel Add/Drop Bus

This block connects one low-rate tributary port to a byte-wide add/drop bus that carries a synchronous frame, one byte per clock. The bus rate is 6.48 MHz when it carries a single signal and 19.44 MHz when it carries three interleaved signals. The block finds its place in the frame from two drop-side inputs. The first is a payload indicator, high for payload bytes and low for overhead bytes. The second is a single timing-pulse line, whose meaning depends on the payload indicator at the time of the pulse. From that position it raises an active-low select strobe during the byte slots of one programmed tributary.

On the add side the block drives a tributary byte, an add flag and a parity bit onto a shared tristate bus. It drives them only during the selected slots and leaves the bus floating at all other times. A build-time parameter picks the timing source for the add side. In drop timing, the add side follows the drop bus and lags it by one byte. In add timing, the add side uses a separate add clock and its own indicator pair, and samples both indicators on the falling edge of that clock.

Top module: `trib_slot_if`

## Requirements
- R1: While reset is asserted and straight after it, the select strobe is high and the add bus, add flag and parity are not driven (high impedance).
- R2: No slot is selected until a timing pulse arrives with the payload indicator high. A pulse with the payload indicator low (a frame-start marker) does not start tracking.
- R3: A payload row is 87 columns, with the pulsed column as column 0. Columns 0, 29 and 58 carry no tributary data. The remaining columns are numbered k = 0..83 in order, and a column is selected when k mod 28 equals `slot_num` (0..27).
- R4: The strobe `sel_n` is low during the clock cycle that follows a selected byte's sampling edge, and only while `drop_en` is 1.
- R5: For each selected byte, the add bus carries the `trib_byte` value that was presented with that byte, and `add_flag` is 1. In drop timing the add slot comes exactly one byte after the drop slot.
- R6: Outside selected add slots, `add_bus`, `add_flag` and `add_par` are high impedance.
- R7: When `par_even` is 0, `add_par` makes the nine bits {add_bus, add_par} odd in ones. When `par_even` is 1, it makes them even.
- R8: Once tracking has started, further timing pulses with the payload indicator high at positions other than the frame origin have no effect on slot selection.
- R9: If the payload byte at the expected frame origin (row 0, column 0 of a 9-row frame) arrives without a pulse, tracking is dropped and nothing is selected until the next pulse with the payload indicator high.
- R10: With the add-timing build option, the add side takes its indicators from `add_spe` and `add_tp`, sampled on the falling edge of `add_clk`, and ignores the drop indicators. The add outputs then follow R5 to R7, one add-clock cycle after the byte.
- R11: Bytes with the payload indicator low are never selected and do not advance the column count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Drop bus byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_num | input | 5 | Programmed tributary slot, 0..27 |
| drop_en | input | 1 | Enables the drop select strobe |
| par_even | input | 1 | 0: odd add parity, 1: even add parity |
| drop_spe | input | 1 | Drop payload indicator |
| drop_tp | input | 1 | Drop timing pulse (frame start or payload start) |
| sel_n | output | 1 | Active-low tributary select strobe |
| add_clk | input | 1 | Add bus clock (add-timing build only) |
| add_spe | input | 1 | Add payload indicator (add-timing build only) |
| add_tp | input | 1 | Add timing pulse (add-timing build only) |
| trib_byte | input | 8 | Tributary byte offered for the add bus |
| add_bus | output | 8 | Tristate add data |
| add_flag | output | 1 | Tristate add indicator, 1 when driving |
| add_par | output | 1 | Tristate add parity |

## Verification
A wrong column or slot count shows up as a strobe and an add burst in the wrong column, within one byte of the first affected column. It then repeats every 28 tributary columns for the rest of the frame. A wrong lock state shows up across a whole frame: a frame that should be silent shows selections, or a locked frame shows none, starting at the first selectable column. Stale add data or a wrong parity sense is visible on the first add slot after the fault, because every slot compares the bus byte and the parity bit against the byte that was offered.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
   typedef enum logic {
      TM_DROP = 1'b0,
      TM_ADD  = 1'b1
   } timing_e;
endpackage

// File: rtl/tsi_slot_tracker.sv
`timescale 1ns/1ps
module tsi_slot_tracker #(
   parameter int ROW_COLS  = 87,
   parameter int ROWS      = 9,
   parameter int STUFF_A   = 29,
   parameter int STUFF_B   = 58,
   parameter int NUM_SLOTS = 28,
   localparam int COL_W    = $clog2(ROW_COLS),
   localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spe,
   input  logic              tp,
   input  logic [SLOT_W-1:0] slot_sel,
   output logic              locked,
   output logic              hit
);
   localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(ROW_COLS - 1);
   localparam logic [COL_W-1:0]  STUFF_A_C = COL_W'(STUFF_A);
   localparam logic [COL_W-1:0]  STUFF_B_C = COL_W'(STUFF_B);
   localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROWS - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

   logic [COL_W-1:0]  col_q;
   logic [ROW_W-1:0]  row_q;
   logic [SLOT_W-1:0] slot_q;
   logic              locked_q;
   logic              at_origin, acquire, miss, is_stuff, is_trib;

   // position decode for the byte on the bus now
   always_comb begin
      at_origin = (col_q == '0) && (row_q == '0);
      acquire   = spe & tp & (~locked_q | at_origin);
      miss      = spe & locked_q & at_origin & ~tp;
      is_stuff  = (col_q == STUFF_A_C) | (col_q == STUFF_B_C);
      is_trib   = spe & locked_q & (col_q != '0) & ~is_stuff;
   end

   assign hit    = is_trib & (slot_q == slot_sel);
   assign locked = locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         col_q    <= '0;
         row_q    <= '0;
         slot_q   <= '0;
      end else if (acquire) begin
         locked_q <= 1'b1;
         col_q    <= COL_W'(1);
         row_q    <= '0;
         slot_q   <= '0;
      end else if (miss) begin
         locked_q <= 1'b0;
         col_q    <= '0;
         row_q    <= '0;
         slot_q   <= '0;
      end else if (spe & locked_q) begin
         if (col_q == LAST_COL) begin
            col_q  <= '0;
            row_q  <= (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
            slot_q <= '0;
         end else begin
            col_q <= col_q + 1'b1;
            if (is_trib)
               slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tsi_add_driver.sv
`timescale 1ns/1ps
module tsi_add_driver #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   input  logic              par_even,
   output logic              act,
   output logic [DATA_W-1:0] dq,
   output logic              pv
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0;
         dq  <= '0;
      end else begin
         act <= take;
         if (take)
            dq <= din;
      end
   end

   assign pv = par_even ? (^dq) : ~(^dq);
endmodule

// File: rtl/trib_slot_if.sv
`timescale 1ns/1ps
module trib_slot_if
   import tsi_pkg::*;
#(
   parameter int      DATA_W    = 8,
   parameter int      ROW_COLS  = 87,
   parameter int      ROWS      = 9,
   parameter int      STUFF_A   = 29,
   parameter int      STUFF_B   = 58,
   parameter int      NUM_SLOTS = 28,
   parameter timing_e TIMING    = TM_DROP,
   localparam int     SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] slot_num,
   input  logic              drop_en,
   input  logic              par_even,
   input  logic              drop_spe,
   input  logic              drop_tp,
   output logic              sel_n,
   input  logic              add_clk,
   input  logic              add_spe,
   input  logic              add_tp,
   input  logic [DATA_W-1:0] trib_byte,
   output logic [DATA_W-1:0] add_bus,
   output logic              add_flag,
   output logic              add_par
);
   // elaboration checks
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be at least 1");
   end
   if (STUFF_A < 1 || STUFF_B <= STUFF_A || STUFF_B >= ROW_COLS) begin : g_bad_stuff
      $error("stuff columns must lie inside the row in rising order");
   end
   if (((ROW_COLS - 3) % NUM_SLOTS) != 0) begin : g_bad_slots
      $error("tributary columns per row must be a multiple of NUM_SLOTS");
   end

   logic              drop_hit, drop_locked, sel_q;
   logic              side_clk, add_act, add_pv;
   logic [DATA_W-1:0] add_dq;

   tsi_slot_tracker #(
      .ROW_COLS(ROW_COLS), .ROWS(ROWS), .STUFF_A(STUFF_A),
      .STUFF_B(STUFF_B), .NUM_SLOTS(NUM_SLOTS)
   ) u_trk_drop (
      .clk(clk), .rst_n(rst_n), .spe(drop_spe), .tp(drop_tp),
      .slot_sel(slot_num), .locked(drop_locked), .hit(drop_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= drop_hit;
   end
   assign sel_n = ~(sel_q & drop_en);

   if (TIMING == TM_ADD) begin : g_add_timed
      logic a_spe, a_tp, a_hit, a_locked_unused;

      always_ff @(negedge add_clk or negedge rst_n) begin
         if (!rst_n) begin
            a_spe <= 1'b0;
            a_tp  <= 1'b0;
         end else begin
            a_spe <= add_spe;
            a_tp  <= add_tp;
         end
      end

      tsi_slot_tracker #(
         .ROW_COLS(ROW_COLS), .ROWS(ROWS), .STUFF_A(STUFF_A),
         .STUFF_B(STUFF_B), .NUM_SLOTS(NUM_SLOTS)
      ) u_trk_add (
         .clk(add_clk), .rst_n(rst_n), .spe(a_spe), .tp(a_tp),
         .slot_sel(slot_num), .locked(a_locked_unused), .hit(a_hit)
      );

      tsi_add_driver #(.DATA_W(DATA_W)) u_drv (
         .clk(add_clk), .rst_n(rst_n), .take(a_hit), .din(trib_byte),
         .par_even(par_even), .act(add_act), .dq(add_dq), .pv(add_pv)
      );
      assign side_clk = add_clk;
   end else begin : g_drop_timed
      logic unused_add_side;
      assign unused_add_side = ^{add_clk, add_spe, add_tp};

      tsi_add_driver #(.DATA_W(DATA_W)) u_drv (
         .clk(clk), .rst_n(rst_n), .take(drop_hit), .din(trib_byte),
         .par_even(par_even), .act(add_act), .dq(add_dq), .pv(add_pv)
      );
      assign side_clk = clk;
   end

   assign add_bus  = add_act ? add_dq : {DATA_W{1'bz}};
   assign add_flag = add_act ? 1'b1   : 1'bz;
   assign add_par  = add_act ? add_pv : 1'bz;
endmodule

// File: rtl/trib_slot_if_chk.sv
`timescale 1ns/1ps
module trib_slot_if_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              drop_spe,
   input logic              drop_tp,
   input logic              drop_locked,
   input logic              sel_n,
   input logic              side_clk,
   input logic              add_act,
   input logic [DATA_W-1:0] add_dq,
   input logic              add_pv,
   input logic              par_even,
   input logic [DATA_W-1:0] trib_byte
);
   p_acquire_on_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drop_locked) |-> $past(drop_spe && drop_tp));

   p_sel_needs_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n |-> $past(drop_locked));

   p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n |=> sel_n);

   p_add_data_r5: assert property (@(posedge side_clk) disable iff (!rst_n)
      add_act |-> (add_dq == $past(trib_byte)));

   p_parity_sense_r7: assert property (@(posedge side_clk) disable iff (!rst_n)
      add_act |-> ((^{add_dq, add_pv}) == ~par_even));

   p_unlock_on_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drop_locked) |-> $past(drop_spe && !drop_tp));

   p_sel_in_payload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n |-> $past(drop_spe));
endmodule

bind trib_slot_if trib_slot_if_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .drop_spe(drop_spe), .drop_tp(drop_tp),
   .drop_locked(drop_locked), .sel_n(sel_n), .side_clk(side_clk),
   .add_act(add_act), .add_dq(add_dq), .add_pv(add_pv),
   .par_even(par_even), .trib_byte(trib_byte)
);

// File: tb/trib_slot_if_test.sv
`timescale 1ns/1ps
module trib_slot_if_test;
   import tsi_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] slot_num = '0;
   logic       drop_en = 1'b1;
   logic       par_even = 1'b0;
   logic       spe = 1'b0;
   logic       tp = 1'b0;
   logic [7:0] trib_byte = '0;

   wire        sel_d, sel_a;
   wire [7:0]  bus_d, bus_a;
   wire        flag_d, flag_a, par_d, par_a;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   for (genvar i = 0; i < 8; i++) begin : g_pu
      pullup pu_d (bus_d[i]);
      pullup pu_a (bus_a[i]);
   end
   pulldown pd_fd (flag_d);
   pulldown pd_fa (flag_a);
   pulldown pd_pd (par_d);
   pulldown pd_pa (par_a);

   trib_slot_if #(.TIMING(TM_DROP)) uut (
      .clk(clk), .rst_n(rst_n), .slot_num(slot_num), .drop_en(drop_en),
      .par_even(par_even), .drop_spe(spe), .drop_tp(tp), .sel_n(sel_d),
      .add_clk(clk), .add_spe(1'b0), .add_tp(1'b0), .trib_byte(trib_byte),
      .add_bus(bus_d), .add_flag(flag_d), .add_par(par_d)
   );

   // add-timed variant: drop indicators hold no timing at all
   trib_slot_if #(.TIMING(TM_ADD)) uut_a (
      .clk(clk), .rst_n(rst_n), .slot_num(slot_num), .drop_en(drop_en),
      .par_even(par_even), .drop_spe(1'b1), .drop_tp(1'b0), .sel_n(sel_a),
      .add_clk(clk), .add_spe(spe), .add_tp(tp), .trib_byte(trib_byte),
      .add_bus(bus_a), .add_flag(flag_a), .add_par(par_a)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit col_hit(int pc, int slot);
      int k;
      if (pc == 0 || pc == 29 || pc == 58) return 1'b0;
      k = pc - 1 - ((pc > 29) ? 1 : 0) - ((pc > 58) ? 1 : 0);
      return (k % 28) == slot;
   endfunction

   task automatic check_add(input logic [7:0] b, input logic f, input logic p,
                            input bit hit, input logic [7:0] eb, input string who);
      logic ep;
      ep = par_even ? ^eb : ~^eb;
      if (hit) begin
         chk(b === eb, {who, " R5 add data"}, b, eb);
         chk(f === 1'b1, {who, " R5 add flag"}, {7'b0, f}, 8'h01);
         chk(p === ep, {who, " R7 parity"}, {7'b0, p}, {7'b0, ep});
      end else begin
         chk(b === 8'hff, {who, " R6 bus idle"}, b, 8'hff);
         chk(f === 1'b0, {who, " R6 flag idle"}, {7'b0, f}, 8'h00);
      end
   endtask

   // present one byte, then check the cycle after its sampling edge
   task automatic step(input logic s, input logic t, input bit hit,
                       input logic [7:0] b, input string tag);
      logic esel;
      spe = s; tp = t; trib_byte = b;
      @(posedge clk); #1;
      esel = ~(hit & drop_en);
      chk(sel_d === esel, {tag, " R4 strobe"}, {7'b0, sel_d}, {7'b0, esel});
      chk(sel_a === 1'b1, "R10 drop side unlocked", {7'b0, sel_a}, 8'h01);
      check_add(bus_d, flag_d, par_d, hit, b, {tag, " drop-timed"});
      check_add(bus_a, flag_a, par_a, hit, b, {tag, " R10 add-timed"});
   endtask

   task automatic send_frame(input bit with_j1, input bit v1, input string tag);
      for (int row = 0; row < 9; row++) begin
         for (int c = 0; c < 3; c++)
            step(1'b0, (row == 0 && c == 0), 1'b0, 8'(row * 3 + c), {tag, " R11"});
         for (int pc = 0; pc < 87; pc++) begin
            logic t;
            bit   h;
            t = (row == 0 && pc == 0 && with_j1) || (v1 && row == 2 && pc == 40);
            h = with_j1 && col_hit(pc, int'(slot_num));
            step(1'b1, t, h, 8'((row * 87 + pc) * 13 + int'(slot_num)),
                 (v1 ? {tag, " R8"} : tag));
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(sel_d === 1'b1, "R1 strobe in reset", {7'b0, sel_d}, 8'h01);
      chk(bus_d === 8'hff, "R1 bus in reset", bus_d, 8'hff);
      chk(flag_d === 1'b0, "R1 flag in reset", {7'b0, flag_d}, 8'h00);
      chk(flag_a === 1'b0, "R1 add-timed flag in reset", {7'b0, flag_a}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(sel_d === 1'b1, "R1 strobe after reset", {7'b0, sel_d}, 8'h01);
      chk(bus_d === 8'hff, "R1 bus after reset", bus_d, 8'hff);
      // frame-start pulses only: must not start tracking
      slot_num = 5'd3;
      send_frame(1'b0, 1'b0, "R2 no payload pulse");
      // sweep every slot, mixing parity sense, strobe enable and extra pulses
      for (int s = 0; s < 28; s++) begin
         slot_num = 5'(s);
         par_even = s[0];
         drop_en  = (s % 5) != 3;
         send_frame(1'b1, (s % 3) == 0, "R3 slot sweep");
      end
      // missing origin pulse drops tracking, the next one restores it
      slot_num = 5'd5;
      par_even = 1'b0;
      drop_en  = 1'b1;
      send_frame(1'b0, 1'b0, "R9 missing pulse");
      send_frame(1'b1, 1'b0, "R9 reacquire");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule